// File: doc/BRIEF.md
# I2C Display Command/Data Frame Parser

This block is the serial front end of a display controller. It acts as an I2C slave with separate data input and data output pins, so the output only ever pulls the line low. The system clock oversamples SCL and SDA. Both lines pass through a two-stage synchronizer and a stable-count filter before any edge is detected. After a START the block compares the 7-bit address with its own. The upper six address bits are fixed and the lowest bit comes from a pin.

In a write transaction, each control byte after the address sets two things: whether more control bytes follow, and whether the data bytes are commands or display memory writes. Each data byte is then sent out on a command strobe or on a RAM write strobe.

In a read transaction, the block returns bytes MSB first, starting straight after the address acknowledge. The bytes come either from display memory or from a status byte. The choice depends on the most recent target bit received in any earlier write transaction.

Top module: `i2c_frame_slave`

## Requirements
- R1: The block acknowledges an address byte equal to `{ADDR_HI, addrSel, rw}` (default upper bits 011110) by holding `sdaOut` low through the ninth SCL clock.
- R2: On an address mismatch the block holds `sdaOut` high and raises no strobe until the next START, then responds normally.
- R3: SDA falling while SCL is high pulses `busStart`, and SDA rising while SCL is high pulses `busStop`. After either, `sdaOut` is released.
- R4: The first byte after a write address is a control byte. Bit 7 is the continuation flag and bit 6 is the target (1 = RAM, 0 = command). The control byte is acknowledged and produces no output strobe.
- R5: With the continuation flag at 1, exactly one data byte follows, and the next byte is again a control byte.
- R6: With the continuation flag at 0, every byte up to the next STOP or START is a data byte, even when its upper bits look like a control byte.
- R7: Each data byte is acknowledged. With target 0 it pulses `cmdValid` with `cmdByte`; with target 1 it pulses `ramWrValid` with `ramWrByte`, inside the acknowledge cycle while `sdaOut` is low.
- R8: After a read address is acknowledged, bytes are shifted out MSB first. They come from `ramRdByte` if the last received target bit was 1, otherwise from `statusByte`. This selection persists across transactions and is 0 (status) after reset.
- R9: Each RAM byte loaded for transmission pulses `ramRdReq` once. After a master ACK the next byte is loaded.
- R10: After a master NACK, `sdaOut` stays high and no further byte is loaded until a START.
- R11: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks has no effect on bus decoding.
- R12: After reset `sdaOut` is high and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| addrSel | input | 1 | Lowest bit of the slave address |
| sdaOut | output | 1 | Open-drain style data output, 0 pulls the line low |
| busStart | output | 1 | One-cycle pulse on START or repeated START |
| busStop | output | 1 | One-cycle pulse on STOP |
| cmdValid | output | 1 | One-cycle pulse, command byte delivered |
| cmdByte | output | 8 | Command byte value |
| ramWrValid | output | 1 | One-cycle pulse, display memory write |
| ramWrByte | output | 8 | Display memory write value |
| ramRdReq | output | 1 | One-cycle pulse, a RAM byte was taken for transmission |
| ramRdByte | input | 8 | Display memory byte at the current read pointer |
| statusByte | input | 8 | Status byte returned when the target bit is 0 |

## Verification
The bench builds the block with `FILT_CYCLES` set to 4 instead of the default 10, and with an SCL half period of 40 system clocks. The short filter lets a 2-clock pulse on either line, well below the threshold, exercise glitch rejection both on an idle bus and in the middle of a data bit, with no long runs. The default address bits are kept, and `addrSel` is changed between transactions so that both slave addresses and a mismatch are covered. A counting model of the read pointer drives `ramRdByte` so that the byte order and the one-request-per-byte rule can be checked.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_TX,
    ST_IGNORE
  } busState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clrCnt;
    logic sampleBit;
    logic latchCtrl;
    logic deliver;
    logic loadTx;
    logic shiftTx;
    logic driveLow;
    logic releaseLine;
  } strobe_t;

endpackage

// File: rtl/ifs_glitch_filter.sv
module ifs_glitch_filter #(
  parameter int STABLE_CYCLES = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      cnt     <= '0;
      lineOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], lineIn};
      if (syncQ[1] == lineOut) begin
        cnt <= '0;
      end else if (cnt == CW'(STABLE_CYCLES - 1)) begin
        lineOut <= syncQ[1];
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ifs_ctrl.sv
module ifs_ctrl
  import ifs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      byteFull,
  input  logic      coFlag,
  output strobe_t   strb,
  output busState_t busState,
  output logic      busStart,
  output logic      busStop
);
  logic      sclQ, sdaQ;
  logic      ackPhase, ackNext;
  busState_t stNext;
  logic      sclRise, sclFall, startCond, stopCond;

  assign sclRise   = sclF & ~sclQ;
  assign sclFall   = ~sclF & sclQ;
  assign startCond = sclF & sclQ & sdaQ & ~sdaF;
  assign stopCond  = sclF & sclQ & ~sdaQ & sdaF;

  always_comb begin
    strb    = '0;
    stNext  = busState;
    ackNext = ackPhase;
    if (startCond) begin
      stNext           = ST_ADDR;
      ackNext          = 1'b0;
      strb.clrCnt      = 1'b1;
      strb.releaseLine = 1'b1;
    end else if (stopCond) begin
      stNext           = ST_IDLE;
      ackNext          = 1'b0;
      strb.clrCnt      = 1'b1;
      strb.releaseLine = 1'b1;
    end else begin
      case (busState)
        ST_ADDR, ST_CTRL, ST_DATA: begin
          if (sclRise && !byteFull && !ackPhase) begin
            strb.sampleBit = 1'b1;
          end else if (sclFall && byteFull && !ackPhase) begin
            if (busState == ST_ADDR && !addrMatch) begin
              stNext = ST_IGNORE;
            end else begin
              strb.driveLow  = 1'b1;
              ackNext        = 1'b1;
              strb.deliver   = (busState == ST_DATA);
              strb.latchCtrl = (busState == ST_CTRL);
            end
          end else if (sclFall && ackPhase) begin
            ackNext     = 1'b0;
            strb.clrCnt = 1'b1;
            if (busState == ST_ADDR && rwBit) begin
              stNext      = ST_TX;
              strb.loadTx = 1'b1;
            end else begin
              strb.releaseLine = 1'b1;
              if (busState == ST_ADDR)      stNext = ST_CTRL;
              else if (busState == ST_CTRL) stNext = ST_DATA;
              else                          stNext = coFlag ? ST_CTRL : ST_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclRise && !ackPhase && !byteFull) begin
            strb.sampleBit = 1'b1;
          end else if (sclRise && ackPhase) begin
            if (sdaF) begin
              stNext  = ST_IGNORE;
              ackNext = 1'b0;
            end
          end else if (sclFall && ackPhase) begin
            ackNext     = 1'b0;
            strb.clrCnt = 1'b1;
            strb.loadTx = 1'b1;
          end else if (sclFall && byteFull) begin
            strb.releaseLine = 1'b1;
            ackNext          = 1'b1;
          end else if (sclFall) begin
            strb.shiftTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      busState <= ST_IDLE;
      ackPhase <= 1'b0;
      busStart <= 1'b0;
      busStop  <= 1'b0;
    end else begin
      sclQ     <= sclF;
      sdaQ     <= sdaF;
      busState <= stNext;
      ackPhase <= ackNext;
      busStart <= startCond;
      busStop  <= stopCond;
    end
  end
endmodule

// File: rtl/ifs_datapath.sv
module ifs_datapath
  import ifs_pkg::*;
#(
  parameter logic [5:0] ADDR_HI   = 6'b011110,
  parameter int         BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic                 sdaF,
  input  logic                 addrSel,
  input  logic [BYTE_BITS-1:0] ramRdByte,
  input  logic [BYTE_BITS-1:0] statusByte,
  output logic                 addrMatch,
  output logic                 rwBit,
  output logic                 byteFull,
  output logic                 coFlag,
  output logic                 sdaOut,
  output logic                 cmdValid,
  output logic [BYTE_BITS-1:0] cmdByte,
  output logic                 ramWrValid,
  output logic [BYTE_BITS-1:0] ramWrByte,
  output logic                 ramRdReq
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  logic [BYTE_BITS-1:0] rxShift, txShift, txSrc;
  logic [CNT_W-1:0]     bitCnt;
  logic                 dcSel;

  assign byteFull  = (bitCnt == CNT_W'(BYTE_BITS));
  assign rwBit     = rxShift[0];
  assign addrMatch = (rxShift[BYTE_BITS-1:1] == {ADDR_HI, addrSel});
  assign txSrc     = dcSel ? ramRdByte : statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      bitCnt     <= '0;
      coFlag     <= 1'b0;
      dcSel      <= 1'b0;
      sdaOut     <= 1'b1;
      cmdValid   <= 1'b0;
      cmdByte    <= '0;
      ramWrValid <= 1'b0;
      ramWrByte  <= '0;
      ramRdReq   <= 1'b0;
    end else begin
      cmdValid   <= 1'b0;
      ramWrValid <= 1'b0;
      ramRdReq   <= 1'b0;

      if (strb.clrCnt) begin
        bitCnt <= '0;
      end else if (strb.sampleBit) begin
        rxShift <= {rxShift[BYTE_BITS-2:0], sdaF};
        bitCnt  <= bitCnt + 1'b1;
      end

      if (strb.latchCtrl) begin
        coFlag <= rxShift[BYTE_BITS-1];
        dcSel  <= rxShift[BYTE_BITS-2];
      end

      if (strb.deliver) begin
        if (dcSel) begin
          ramWrValid <= 1'b1;
          ramWrByte  <= rxShift;
        end else begin
          cmdValid <= 1'b1;
          cmdByte  <= rxShift;
        end
      end

      if (strb.loadTx) begin
        txShift  <= {txSrc[BYTE_BITS-2:0], 1'b0};
        sdaOut   <= txSrc[BYTE_BITS-1];
        ramRdReq <= dcSel;
      end else if (strb.shiftTx) begin
        sdaOut  <= txShift[BYTE_BITS-1];
        txShift <= {txShift[BYTE_BITS-2:0], 1'b0};
      end else if (strb.driveLow) begin
        sdaOut <= 1'b0;
      end else if (strb.releaseLine) begin
        sdaOut <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_frame_slave.sv
module i2c_frame_slave
  import ifs_pkg::*;
#(
  parameter int         FILT_CYCLES = 10,
  parameter logic [5:0] ADDR_HI     = 6'b011110
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  output logic       sdaOut,
  output logic       busStart,
  output logic       busStop,
  output logic       cmdValid,
  output logic [7:0] cmdByte,
  output logic       ramWrValid,
  output logic [7:0] ramWrByte,
  output logic       ramRdReq,
  input  logic [7:0] ramRdByte,
  input  logic [7:0] statusByte
);
  logic [1:0] rawLines, filtLines;
  strobe_t    strb;
  busState_t  busState;
  logic       addrMatch, rwBit, byteFull, coFlag;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    ifs_glitch_filter #(.STABLE_CYCLES(FILT_CYCLES)) filt_i (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (rawLines[g]),
      .lineOut(filtLines[g])
    );
  end

  ifs_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclF     (filtLines[0]),
    .sdaF     (filtLines[1]),
    .addrMatch(addrMatch),
    .rwBit    (rwBit),
    .byteFull (byteFull),
    .coFlag   (coFlag),
    .strb     (strb),
    .busState (busState),
    .busStart (busStart),
    .busStop  (busStop)
  );

  ifs_datapath #(.ADDR_HI(ADDR_HI), .BYTE_BITS(8)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sdaF      (filtLines[1]),
    .addrSel   (addrSel),
    .ramRdByte (ramRdByte),
    .statusByte(statusByte),
    .addrMatch (addrMatch),
    .rwBit     (rwBit),
    .byteFull  (byteFull),
    .coFlag    (coFlag),
    .sdaOut    (sdaOut),
    .cmdValid  (cmdValid),
    .cmdByte   (cmdByte),
    .ramWrValid(ramWrValid),
    .ramWrByte (ramWrByte),
    .ramRdReq  (ramRdReq)
  );
endmodule

// File: rtl/ifs_checker.sv
module ifs_checker
  import ifs_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sdaOut,
  input logic      busStart,
  input logic      busStop,
  input logic      cmdValid,
  input logic      ramWrValid,
  input logic      ramRdReq,
  input busState_t busState
);
  // R7
  strobe_in_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid || ramWrValid) |-> !sdaOut);

  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && ramWrValid));

  // R3
  start_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busStart |-> (sdaOut && busState == ST_ADDR));

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    busStop |-> (sdaOut && busState == ST_IDLE));

  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IGNORE) |-> (sdaOut && !cmdValid && !ramWrValid && !ramRdReq));

  // R9
  rdreq_in_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramRdReq |-> (busState == ST_TX));

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE) |-> (sdaOut && !cmdValid && !ramWrValid));
endmodule

bind i2c_frame_slave ifs_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .sdaOut    (sdaOut),
  .busStart  (busStart),
  .busStop   (busStop),
  .cmdValid  (cmdValid),
  .ramWrValid(ramWrValid),
  .ramRdReq  (ramRdReq),
  .busState  (busState)
);

// File: tb/i2c_frame_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_frame_slave_tb_top;
  localparam int H = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1, addrSel = 1'b0;
  logic sdaOut, busStart, busStop, cmdValid, ramWrValid, ramRdReq;
  logic [7:0] cmdByte, ramWrByte, ramRdByte, statusByte;
  logic sdaLine;

  int checks = 0, errors = 0;
  int cmdCnt = 0, ramCnt = 0, startCnt = 0, stopCnt = 0, rdPtr = 0;
  int lowCnt = 0, wrOutsideAck = 0;
  logic [7:0] lastCmd = '0, lastRam = '0;
  bit done = 0;

  // bits: [9] addrSel, [8] target, [7:0] data
  localparam logic [9:0] VECS [0:5] = '{
    {1'b0, 1'b0, 8'h21}, {1'b0, 1'b1, 8'hA5}, {1'b1, 1'b0, 8'h0C},
    {1'b1, 1'b1, 8'h80}, {1'b0, 1'b1, 8'h00}, {1'b1, 1'b0, 8'hFF}
  };

  always #2.5 clk = ~clk;

  assign sdaLine    = mSda & sdaOut;
  assign ramRdByte  = 8'h30 + rdPtr[7:0];
  assign statusByte = 8'h5C;

  i2c_frame_slave #(.FILT_CYCLES(4)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaOut(sdaOut), .busStart(busStart), .busStop(busStop),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .ramWrValid(ramWrValid),
    .ramWrByte(ramWrByte), .ramRdReq(ramRdReq), .ramRdByte(ramRdByte),
    .statusByte(statusByte)
  );

  always @(negedge clk) if (rstN) begin
    if (cmdValid) begin cmdCnt++; lastCmd = cmdByte; end
    if (ramWrValid) begin ramCnt++; lastRam = ramWrByte; if (sdaOut) wrOutsideAck++; end
    if (ramRdReq) rdPtr++;
    if (busStart) startCnt++;
    if (busStop) stopCnt++;
    if (!sdaOut) lowCnt++;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStartSeq();
    mSda = 1'b1; waitClk(H); mScl = 1'b1; waitClk(H);
    mSda = 1'b0; waitClk(H); mScl = 1'b0; waitClk(H);
  endtask

  task automatic busStopSeq();
    mSda = 1'b0; waitClk(H); mScl = 1'b1; waitClk(H); mSda = 1'b1; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output logic ackBit);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitClk(H);
      mScl = 1'b1;
      if (glitch && i == 3) begin
        waitClk(H/2); mScl = 1'b0; waitClk(2); mScl = 1'b1; waitClk(H/2 - 2);
      end else begin
        waitClk(H);
      end
      mScl = 1'b0;
    end
    mSda = 1'b1; waitClk(H);
    mScl = 1'b1; waitClk(H/2); ackBit = sdaLine; waitClk(H/2); mScl = 1'b0;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mSda = 1'b1; waitClk(H);
      mScl = 1'b1; waitClk(H/2); b[i] = sdaLine; waitClk(H/2); mScl = 1'b0;
    end
    mSda = ackIt ? 1'b0 : 1'b1; waitClk(H);
    mScl = 1'b1; waitClk(H); mScl = 1'b0; waitClk(H/4); mSda = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic a;
    logic [7:0] rd;
    int c0, r0, s0, p0, l0, k0;

    waitClk(10);
    // R12 reset state
    check("R12 sdaOut after reset", sdaOut, 1);
    check("R12 strobes after reset", {cmdValid, ramWrValid, ramRdReq, busStart}, 0);
    rstN = 1'b1;
    waitClk(20);

    // R8 default source is status
    p0 = rdPtr;
    busStartSeq();
    sendByte(8'h78 | 8'h01, 0, a);
    check("R1 read address ack", a, 0);
    recvByte(1'b0, rd);
    check("R8 default read returns status", rd, 8'h5C);
    busStopSeq();
    check("R9 no RAM request for status", rdPtr - p0, 0);

    // vector table: single data byte writes
    s0 = startCnt; k0 = stopCnt;
    for (int v = 0; v < 6; v++) begin
      logic [9:0] e;
      e = VECS[v];
      addrSel = e[9];
      c0 = cmdCnt; r0 = ramCnt;
      busStartSeq();
      sendByte({6'b011110, e[9], 1'b0}, 0, a);
      check("R1 address ack", a, 0);
      sendByte({1'b0, e[8], 6'b0}, 0, a);
      check("R4 control byte ack", a, 0);
      sendByte(e[7:0], 0, a);
      check("R7 data byte ack", a, 0);
      busStopSeq();
      if (e[8]) begin
        check("R7 RAM write count", ramCnt - r0, 1);
        check("R7 RAM write byte", lastRam, e[7:0]);
        check("R7 no command on RAM target", cmdCnt - c0, 0);
      end else begin
        check("R7 command count", cmdCnt - c0, 1);
        check("R7 command byte", lastCmd, e[7:0]);
        check("R7 no RAM write on command target", ramCnt - r0, 0);
      end
      check("R3 sdaOut released after stop", sdaOut, 1);
    end
    check("R3 start pulses", startCnt - s0, 6);
    check("R3 stop pulses", stopCnt - k0, 6);

    // R5 interleaved control/data with continuation flag
    addrSel = 1'b0;
    c0 = cmdCnt; r0 = ramCnt;
    busStartSeq();
    sendByte(8'h78, 0, a);
    sendByte(8'h80, 0, a);
    sendByte(8'h21, 0, a);
    sendByte(8'hC0, 0, a);
    check("R4 second control byte ack", a, 0);
    sendByte(8'h5A, 0, a);
    sendByte(8'h00, 0, a);
    sendByte(8'h0C, 0, a);
    sendByte(8'h81, 0, a);
    busStopSeq();
    check("R5 command count interleaved", cmdCnt - c0, 3);
    check("R5 RAM count interleaved", ramCnt - r0, 1);
    check("R5 RAM byte interleaved", lastRam, 8'h5A);
    check("R4 last command byte", lastCmd, 8'h81);

    // R6 data stream without continuation
    c0 = cmdCnt; r0 = ramCnt;
    busStartSeq();
    sendByte(8'h78, 0, a);
    sendByte(8'h40, 0, a);
    sendByte(8'h80, 0, a);
    sendByte(8'hC0, 0, a);
    sendByte(8'h3E, 0, a);
    busStopSeq();
    check("R6 stream RAM count", ramCnt - r0, 3);
    check("R6 stream command count", cmdCnt - c0, 0);
    check("R6 stream last byte", lastRam, 8'h3E);

    // R2 address mismatch
    c0 = cmdCnt; r0 = ramCnt; l0 = lowCnt;
    busStartSeq();
    sendByte(8'h7A, 0, a);
    check("R2 mismatch not acknowledged", a, 1);
    sendByte(8'h00, 0, a);
    sendByte(8'h33, 0, a);
    check("R2 ignored byte not acknowledged", a, 1);
    check("R2 no strobes when ignored", (cmdCnt - c0) + (ramCnt - r0), 0);
    check("R2 sdaOut never low when ignored", lowCnt - l0, 0);
    busStartSeq();
    sendByte(8'h78, 0, a);
    check("R2 responds after next start", a, 0);
    busStopSeq();

    // R11 glitches
    s0 = startCnt;
    mSda = 1'b0; waitClk(2); mSda = 1'b1; waitClk(30);
    check("R11 short SDA pulse gives no start", startCnt - s0, 0);
    c0 = cmdCnt;
    busStartSeq();
    sendByte(8'h78, 0, a);
    sendByte(8'h00, 0, a);
    sendByte(8'hB7, 1, a);
    check("R11 ack after SCL glitch", a, 0);
    busStopSeq();
    check("R11 byte intact after SCL glitch", lastCmd, 8'hB7);
    check("R11 one command after SCL glitch", cmdCnt - c0, 1);

    // R8 status read after a command write, via repeated start
    p0 = rdPtr;
    busStartSeq();
    sendByte(8'h78, 0, a);
    sendByte(8'h00, 0, a);
    sendByte(8'h00, 0, a);
    busStartSeq();
    sendByte(8'h79, 0, a);
    recvByte(1'b0, rd);
    busStopSeq();
    check("R8 status after command target", rd, 8'h5C);
    check("R8 no RAM request", rdPtr - p0, 0);

    // R8/R9/R10 RAM read, target persists across stop
    busStartSeq();
    sendByte(8'h78, 0, a);
    sendByte(8'h40, 0, a);
    sendByte(8'h11, 0, a);
    busStopSeq();
    p0 = rdPtr;
    busStartSeq();
    sendByte(8'h79, 0, a);
    check("R1 read address ack", a, 0);
    recvByte(1'b1, rd);
    check("R8 RAM byte 0", rd, 8'h30 + p0);
    recvByte(1'b1, rd);
    check("R9 RAM byte 1", rd, 8'h30 + p0 + 1);
    recvByte(1'b0, rd);
    check("R9 RAM byte 2", rd, 8'h30 + p0 + 2);
    check("R9 one request per byte", rdPtr - p0, 3);
    recvByte(1'b0, rd);
    check("R10 line released after NACK", rd, 8'hFF);
    check("R10 no load after NACK", rdPtr - p0, 3);
    busStopSeq();

    check("R7 RAM writes only during ack", wrOutsideAck, 0);
    finishRun();
  end
endmodule